// File: doc/BRIEF.md
# Multicart Outer-Bank Extension Register

This block sits next to a standard bank-switching controller on a multigame cartridge and adds one outer level of banking on top of it. A single 6-bit configuration register is loaded from the CPU **address** bus, not the data bus. The load happens on any write into the `$6000-$7FFF` window. The write is accepted only while the controller's work-RAM control bits show the RAM as enabled and writable, and only while the register's outer-block field is still zero. Once a nonzero block has been chosen, the register stays frozen until reset.

The register's fields combine with the controller's inner bank numbers to form the final program and character bank numbers:

- a 3-bit outer block;
- a size flag, which also switches the mirroring mode;
- a flag that routes all character fetches to an 8 KiB character RAM;
- a flag that widens the character ROM window.

While the size flag is set, the block replaces the controller's mirroring with single-screen mirroring. The screen is chosen, fetch by fetch, by bit 7 of the 1 KiB character bank that the PPU is currently reading.

All bank outputs are combinational from the register and the current bus inputs. A mapping change is therefore visible within the same access.

Top module: `multicart_outer_bank`

## Requirements
- R1: The register loads only on a CPU write whose address has bits [15:13] = 3'b011 and while `prg_ram_ctl` = 2'b10. A write with any other control value or outside that window leaves it unchanged.
- R2: The value loaded is `cpu_addr[5:0]`. Bits [2:0] are the outer block, bit 3 is the size flag S, bit 4 is the CHR-RAM flag R, and bit 5 is the CHR-width flag M.
- R3: A write is accepted only while the block field held before that write is zero. A second write is still accepted after a first one that left the block zero. Once the block is nonzero, every later write is ignored.
- R4: Reset, synchronous and active high, clears the register to zero.
- R5: With S=0, `prg_bank` = (block << 4) | (prg_inner & 0x0F).
- R6: With S=1, `prg_bank` = (block << 4) | (prg_inner & 0x1F), so inner bit 4 ORs into block bit 0.
- R7: With R=1, `chr_rom_sel` is 0. `chr_ram_addr` = {low 3 bits of the active inner CHR bank, `ppu_addr[9:0]`}. `chr_ram_we` follows `ppu_wr`.
- R8: With R=0 and M=S=1, `chr_rom_bank` = (block << 7) | inner, using all 8 inner bits, and `chr_rom_sel` is 1.
- R9: With R=0 and not both M and S set, `chr_rom_bank` = (block << 7) | (inner & 0x7F). M alone has no effect.
- R10: The active inner CHR bank is slot `ppu_addr[12:10]` of `chr_banks`, where slot k occupies bits [8k+7:8k]. With S=1, `mirror_mode` = {1'b1, bit 7 of that bank}. The encoding is 2 = single screen A and 3 = single screen B.
- R11: With S=0, `mirror_mode` = {1'b0, `core_mirror_h`}, where 0 = vertical and 1 = horizontal.
- R12: With R=0, `chr_ram_we` stays 0 whatever `ppu_wr` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address bus |
| prg_ram_ctl | input | 2 | Controller work-RAM control bits [7:6] |
| prg_inner | input | 5 | Inner 8 KiB program bank for the current access |
| prg_bank | output | 7 | Final 8 KiB program bank |
| chr_banks | input | 64 | Eight inner 1 KiB character bank values |
| ppu_addr | input | 13 | PPU pattern address |
| ppu_wr | input | 1 | PPU write strobe |
| core_mirror_h | input | 1 | Controller mirroring, 1 = horizontal |
| chr_rom_sel | output | 1 | Character access goes to ROM |
| chr_rom_bank | output | 10 | Final 1 KiB character ROM bank |
| chr_ram_addr | output | 13 | Character RAM byte address |
| chr_ram_we | output | 1 | Character RAM write enable |
| mirror_mode | output | 2 | 0 vertical, 1 horizontal, 2/3 single screen A/B |

## Verification
The bench builds the block with its default parameters: a 3-bit block field, a 4-bit normal program window and 8-bit character banks. With these values all 64 register values can be loaded one after another, each following a reset. For each value, every program inner bank and every character inner bank is applied, and every one of the eight PPU slots is swept with bank bit 7 alternating. This covers every S/M/R combination, including the inner-bit-4 overlap and the bit-7 overlap. Directed sequences then exercise the write gate, the self-lock, a legal rewrite while the block is still zero, and reset.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
  localparam int BLK_W = 3;

  typedef struct packed {
    logic             m;    // wide CHR window
    logic             r;    // CHR RAM route
    logic             s;    // size / single-screen mode
    logic [BLK_W-1:0] blk;  // outer block
  } cfg_t;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;
endpackage

// File: rtl/mcx_cfg_reg.sv
module mcx_cfg_reg
  import mcx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_W   = 3,
  parameter logic [WIN_W-1:0] WIN_TAG = 3'b011,
  parameter logic [1:0] CTL_OPEN = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        ram_ctl,
  output cfg_t              cfg_o
);
  localparam int CFG_W = $bits(cfg_t);

  cfg_t cfg_q;
  logic in_win, open, unlocked, take;
  logic unused_addr;

  assign in_win      = cpu_addr[ADDR_W-1 -: WIN_W] == WIN_TAG;
  assign open        = ram_ctl == CTL_OPEN;
  assign unlocked    = cfg_q.blk == '0;
  assign take        = cpu_wr && in_win && open && unlocked;
  assign unused_addr = ^cpu_addr[ADDR_W-WIN_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (take) cfg_q <= cfg_t'(cpu_addr[CFG_W-1:0]);
  end

  assign cfg_o = cfg_q;

  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (ram_ctl != CTL_OPEN) |=> $stable(cfg_q));
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && in_win && open && cfg_q.blk == '0) |=> cfg_q == $past(cpu_addr[CFG_W-1:0]));
  p_lock_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.blk != '0) |=> $stable(cfg_q));
  p_reset_r4: assert property (@(posedge clk)
    rst |=> cfg_q == '0);
endmodule

// File: rtl/mcx_prg_map.sv
module mcx_prg_map
  import mcx_pkg::*;
#(
  parameter int LO_W = 4
) (
  input  cfg_t              cfg,
  input  logic [LO_W:0]     inner,
  output logic [BLK_W+LO_W-1:0] bank
);
  localparam int OUT_W = BLK_W + LO_W;

  logic [LO_W:0]    inner_used;
  logic [OUT_W-1:0] outer;

  always_comb begin
    inner_used = cfg.s ? inner : {1'b0, inner[LO_W-1:0]};
    outer      = {cfg.blk, {LO_W{1'b0}}};
    bank       = outer | OUT_W'(inner_used);
  end

  always_comb begin
    p_blk_kept_r5: assert ((bank[OUT_W-1:LO_W] & cfg.blk) == cfg.blk);
    p_low_r6: assert (bank[LO_W-1:0] == inner[LO_W-1:0]);
  end
endmodule

// File: rtl/mcx_chr_map.sv
module mcx_chr_map
  import mcx_pkg::*;
#(
  parameter int BANK_W     = 8,
  parameter int SLOTS      = 8,
  parameter int PAGE_W     = 10,
  parameter int RAM_BANK_W = 3
) (
  input  cfg_t                          cfg,
  input  logic [SLOTS*BANK_W-1:0]       banks,
  input  logic [$clog2(SLOTS)+PAGE_W-1:0] ppu_addr,
  input  logic                          ppu_wr,
  input  logic                          core_mirror_h,
  output logic                          rom_sel,
  output logic [BLK_W+BANK_W-2:0]       rom_bank,
  output logic [RAM_BANK_W+PAGE_W-1:0]  ram_addr,
  output logic                          ram_we,
  output mirror_e                       mirror
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ROM_W  = BLK_W + BANK_W - 1;

  logic [BANK_W-1:0] bank_arr [SLOTS];
  logic [SLOTS-1:0]  top_bits;
  logic [SLOT_W-1:0] slot;
  logic [BANK_W-1:0] inner;
  logic [BANK_W-1:0] inner_used;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign bank_arr[k] = banks[k*BANK_W +: BANK_W];
    assign top_bits[k] = bank_arr[k][BANK_W-1];
  end

  assign slot  = ppu_addr[PAGE_W +: SLOT_W];
  assign inner = bank_arr[slot];

  always_comb begin
    inner_used = (cfg.m && cfg.s) ? inner : {1'b0, inner[BANK_W-2:0]};
    rom_bank   = {cfg.blk, {(BANK_W-1){1'b0}}} | ROM_W'(inner_used);
    rom_sel    = !cfg.r;
    ram_addr   = {inner[RAM_BANK_W-1:0], ppu_addr[PAGE_W-1:0]};
    ram_we     = cfg.r && ppu_wr;
    if (cfg.s) mirror = top_bits[slot] ? MIR_ONE_B : MIR_ONE_A;
    else       mirror = core_mirror_h ? MIR_HORZ : MIR_VERT;
  end

  always_comb begin
    p_ram_excl_r7: assert (!(rom_sel && ram_we));
    p_single_r10: assert (!cfg.s || mirror inside {MIR_ONE_A, MIR_ONE_B});
    p_pass_r11: assert (cfg.s || mirror inside {MIR_VERT, MIR_HORZ});
  end
endmodule

// File: rtl/multicart_outer_bank.sv
module multicart_outer_bank
  import mcx_pkg::*;
#(
  parameter int PRG_LO_W   = 4,
  parameter int CHR_BANK_W = 8,
  parameter int CHR_SLOTS  = 8,
  parameter int PAGE_W     = 10,
  parameter int RAM_BANK_W = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cpu_wr,
  input  logic [15:0]                         cpu_addr,
  input  logic [1:0]                          prg_ram_ctl,
  input  logic [PRG_LO_W:0]                   prg_inner,
  output logic [BLK_W+PRG_LO_W-1:0]           prg_bank,
  input  logic [CHR_SLOTS*CHR_BANK_W-1:0]     chr_banks,
  input  logic [$clog2(CHR_SLOTS)+PAGE_W-1:0] ppu_addr,
  input  logic                                ppu_wr,
  input  logic                                core_mirror_h,
  output logic                                chr_rom_sel,
  output logic [BLK_W+CHR_BANK_W-2:0]         chr_rom_bank,
  output logic [RAM_BANK_W+PAGE_W-1:0]        chr_ram_addr,
  output logic                                chr_ram_we,
  output logic [1:0]                          mirror_mode
);
  cfg_t    cfg;
  mirror_e mir;

  mcx_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .ram_ctl(prg_ram_ctl), .cfg_o(cfg)
  );

  mcx_prg_map #(.LO_W(PRG_LO_W)) u_prg (
    .cfg(cfg), .inner(prg_inner), .bank(prg_bank)
  );

  mcx_chr_map #(
    .BANK_W(CHR_BANK_W), .SLOTS(CHR_SLOTS),
    .PAGE_W(PAGE_W), .RAM_BANK_W(RAM_BANK_W)
  ) u_chr (
    .cfg(cfg), .banks(chr_banks), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
    .core_mirror_h(core_mirror_h), .rom_sel(chr_rom_sel),
    .rom_bank(chr_rom_bank), .ram_addr(chr_ram_addr),
    .ram_we(chr_ram_we), .mirror(mir)
  );

  assign mirror_mode = mir;
endmodule

// File: tb/multicart_outer_bank_test.sv
module multicart_outer_bank_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        cpu_wr = 0;
  logic [15:0] cpu_addr = 0;
  logic [1:0]  prg_ram_ctl = 2'b10;
  logic [4:0]  prg_inner = 0;
  logic [6:0]  prg_bank;
  logic [63:0] chr_banks = 0;
  logic [12:0] ppu_addr = 0;
  logic        ppu_wr = 0;
  logic        core_mirror_h = 0;
  logic        chr_rom_sel;
  logic [9:0]  chr_rom_bank;
  logic [12:0] chr_ram_addr;
  logic        chr_ram_we;
  logic [1:0]  mirror_mode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  multicart_outer_bank uut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .prg_ram_ctl(prg_ram_ctl), .prg_inner(prg_inner), .prg_bank(prg_bank),
    .chr_banks(chr_banks), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
    .core_mirror_h(core_mirror_h), .chr_rom_sel(chr_rom_sel),
    .chr_rom_bank(chr_rom_bank), .chr_ram_addr(chr_ram_addr),
    .chr_ram_we(chr_ram_we), .mirror_mode(mirror_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic cpu_write(input logic [15:0] a);
    @(negedge clk); cpu_addr = a; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0; cpu_addr = 0;
  endtask

  function automatic int prg_exp(input int v, input int inner);
    int blk = v & 7;
    if (v & 8) return (inner & 'h1F) | (blk << 4);
    return (inner & 'h0F) | (blk << 4);
  endfunction

  // Observe register state through the PRG path and the mirroring path.
  task automatic probe(input string req, input int v);
    prg_inner = 5'h1F; core_mirror_h = 1; chr_banks = {8{8'h80}}; ppu_addr = 0;
    #1;
    chk(req, prg_bank, prg_exp(v, 'h1F));
    chk(req, mirror_mode, (v & 8) ? 3 : 1);
    chk(req, chr_rom_sel, (v & 16) ? 0 : 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R4: reset state
    probe("R4 reset", 0);

    // R1: gate by control bits and address window
    prg_ram_ctl = 2'b00; cpu_write(16'h6009); probe("R1 ctl00", 0);
    prg_ram_ctl = 2'b01; cpu_write(16'h7009); probe("R1 ctl01", 0);
    prg_ram_ctl = 2'b11; cpu_write(16'h6009); probe("R1 ctl11", 0);
    prg_ram_ctl = 2'b10;
    cpu_write(16'h8009); probe("R1 above window", 0);
    cpu_write(16'h5FC9); probe("R1 below window", 0);

    // R3: rewrite allowed while block zero, lock afterwards
    cpu_write(16'h7FC8); probe("R3 first write", 8);
    cpu_write(16'h6011); probe("R3 rewrite", 'h11);
    cpu_write(16'h602E); probe("R3 locked", 'h11);
    prg_ram_ctl = 2'b00; cpu_write(16'h6000); probe("R3 locked ctl", 'h11);
    prg_ram_ctl = 2'b10;

    // R4: reset clears again
    do_reset(); #1; probe("R4 reset after set", 0);

    // R2 R5-R12: sweep all register values
    for (int v = 0; v < 64; v++) begin
      do_reset();
      cpu_write(16'h6000 | 16'(v));
      #1;
      for (int i = 0; i < 32; i++) begin
        prg_inner = 5'(i); #1;
        chk((v & 8) ? "R6 prg" : "R5 prg", prg_bank, prg_exp(v, i));
      end
      for (int i = 0; i < 256; i++) begin
        chr_banks = {8{8'(i)}}; ppu_addr = 13'h0123; ppu_wr = 1; #1;
        if (v & 16) begin
          chk("R7 rom_sel", chr_rom_sel, 0);
          chk("R7 ram addr", chr_ram_addr, ((i & 7) << 10) | 'h123);
          chk("R7 we", chr_ram_we, 1);
        end else begin
          chk("R12 we", chr_ram_we, 0);
          chk("R2 rom_sel", chr_rom_sel, 1);
          if ((v & 'h28) == 'h28)
            chk("R8 chr", chr_rom_bank, i | ((v & 7) << 7));
          else
            chk("R9 chr", chr_rom_bank, (i & 'h7F) | ((v & 7) << 7));
        end
      end
      for (int s = 0; s < 8; s++) begin
        int bv;
        bv = (s * 37 + v * 11) & 'h7F;
        chr_banks[s*8 +: 8] = 8'(bv | ((((s ^ v) & 1) != 0) ? 'h80 : 0));
      end
      for (int s = 0; s < 8; s++) begin
        for (int cm = 0; cm < 2; cm++) begin
          int bv;
          bv = (s * 37 + v * 11) & 'h7F;
          ppu_addr = 13'((s << 10) | 'h2AA); ppu_wr = s[0]; core_mirror_h = cm[0]; #1;
          if (v & 8) chk("R10 mirror", mirror_mode, 2 + ((s ^ v) & 1));
          else       chk("R11 mirror", mirror_mode, cm);
          if (v & 16) begin
            chk("R7 slot addr", chr_ram_addr, ((bv & 7) << 10) | 'h2AA);
            chk("R7 slot we", chr_ram_we, s & 1);
          end else begin
            chk("R12 slot we", chr_ram_we, 0);
          end
        end
      end
      ppu_wr = 0;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule